// File: doc/BRIEF.md
# Four-Lane Clock Compensation Elastic Buffer

This block carries a stream of four-lane character columns from a recovered receive clock into a local clock. Each of the four byte lanes comes with a control flag. The stream is already decoded, so it holds packets and the inter-packet gaps between them. A dual-clock FIFO holds whole columns. The two clocks may drift apart by up to ±100 ppm, and the block absorbs that drift by changing the gaps only:

- When the write side finds the FIFO too full, it discards a column made entirely of /R/ characters.
- When the read side finds it too empty, it emits one extra copy of the /R/ column it has just sent.

Columns that carry packet content are never removed and never repeated.

On the output, every lane that holds one of the three gap control characters (/A/, /K/, /R/) becomes the XGMII Idle character. Start, Data and Terminate lanes pass through unchanged.

After reset, the read side sends Idle columns until half the FIFO is filled.

Top module: `lane_ccomp_fifo`

## Requirements
- R1: While the write-side reset is asserted, `col_drop` and `ovf_err` are 0. While the read-side reset is asserted, `col_ins` and `unf_err` are 0 and the output is an Idle column: data 0x07070707 with all four control bits set. Both sides stay in this state when their reset is released, until their first column is processed.
- R2: After a read-side reset, the output stays an Idle column until the read side has seen at least DEPTH/2 (default 8) stored columns.
- R3: As long as no overflow or underflow occurs, the sequence of output columns that are not all-Idle equals the sequence of translated input columns that are not all-Idle. Columns are neither lost, reordered nor duplicated.
- R4: A column is dropped only if it is an all-/R/ column, meaning all four control bits are set and every byte is 0x1C. It is dropped only when the write-side fill level is 12 or more. `col_drop` pulses for one write clock, one cycle after that column was sampled.
- R5: A column is inserted only when the previous output column came from an all-/R/ column and the read-side fill level is 4 or less. The inserted column is an Idle column, and `col_ins` is high in the same read cycle as that column.
- R6: Lane A is data bits [7:0] with control bit 0, and lane D is bits [31:24] with control bit 3. A lane with its control bit set and a byte of 0x1C, 0x7C or 0xBC leaves as 0x07 with its control bit set. All other lanes, including Start 0xFB and Terminate 0xFD, pass through unchanged.
- R7: A column arriving while the FIFO is full, and not dropped under R4, is discarded. `ovf_err` then goes to 1 and stays there until the write-side reset.
- R8: When the read side has no stored column and does not insert one, `unf_err` goes to 1 and stays there until the read-side reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Write-side reset, active low |
| in_data | input | 32 | Input column, four bytes, lane A lowest |
| in_ctrl | input | 4 | Control flag per input lane |
| col_drop | output | 1 | Pulse: an /R/ column was discarded |
| ovf_err | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst_n | input | 1 | Read-side reset, active low |
| out_data | output | 32 | Output column, translated |
| out_ctrl | output | 4 | Control flag per output lane |
| col_ins | output | 1 | High with an inserted column |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
Timing on the write side is fixed:
- `col_drop` rises one write clock after the dropped column is sampled.
- A write-side error flag is set one write clock after the event.

The bench checks a drop pulse at the next falling write edge, against the column it drove before that edge.

On the read side, the output column, `col_ins` and `unf_err` change one read clock after the decision that causes them. They are sampled on the falling read edge.

The delay from input to output depends on the pointer synchronizers and on the phase between the two clocks. For that reason the data path is checked by order, not by cycle: a queue of expected non-Idle columns is compared against every non-Idle output column.

// File: rtl/ccomp_pkg.sv
package ccomp_pkg;

  localparam int NLANE = 4;

  localparam logic [7:0] CH_R    = 8'h1C;
  localparam logic [7:0] CH_A    = 8'h7C;
  localparam logic [7:0] CH_K    = 8'hBC;
  localparam logic [7:0] CH_IDLE = 8'h07;

  typedef struct packed {
    logic [NLANE-1:0]   ctl;
    logic [8*NLANE-1:0] dat;
  } col_t;

  function automatic logic is_gap_char(logic c, logic [7:0] b);
    return c && (b == CH_R || b == CH_A || b == CH_K);
  endfunction

  function automatic logic is_r_col(col_t c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NLANE; i++) begin
      if (!c.ctl[i] || c.dat[8*i +: 8] != CH_R) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic col_t idle_col();
    col_t o;
    o.ctl = '1;
    o.dat = {NLANE{CH_IDLE}};
    return o;
  endfunction

  function automatic col_t xlate(col_t c);
    col_t o;
    o = c;
    for (int i = 0; i < NLANE; i++) begin
      if (is_gap_char(c.ctl[i], c.dat[8*i +: 8])) o.dat[8*i +: 8] = CH_IDLE;
    end
    return o;
  endfunction

  function automatic logic has_gap_char(col_t c);
    logic f;
    f = 1'b0;
    for (int i = 0; i < NLANE; i++) begin
      if (is_gap_char(c.ctl[i], c.dat[8*i +: 8])) f = 1'b1;
    end
    return f;
  endfunction

endpackage

// File: rtl/ccomp_sync.sv
module ccomp_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ccomp_mem.sv
module ccomp_mem
  import ccomp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  col_t          wdata,
  input  logic [AW-1:0] raddr,
  output col_t          rdata
);
  col_t store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/ccomp_wr.sv
module ccomp_wr
  import ccomp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int HI_MARK = 12,
  parameter int AW      = 4,
  parameter int PW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  col_t          in_col,
  input  logic [PW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          drop_pulse,
  output logic          ovf_err
);
  localparam logic [PW-1:0] HI_P   = PW'(HI_MARK);
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin, fill;
  logic          drop_d, drop_q, ovf_d, ovf_q;
  logic          can_drop, is_full, push;

  always_comb begin
    rbin[PW-1] = rgray_s[PW-1];
    for (int i = PW-2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
  end

  always_comb begin
    fill     = wbin_q - rbin;
    can_drop = is_r_col(in_col) && (fill >= HI_P);
    is_full  = (fill == FULL_P);
    push     = !can_drop && !is_full;
    wbin_d   = push ? wbin_q + 1'b1 : wbin_q;
    wgray_d  = wbin_d ^ (wbin_d >> 1);
    drop_d   = can_drop;
    ovf_d    = ovf_q | (!can_drop && is_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      drop_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      drop_q  <= drop_d;
      ovf_q   <= ovf_d;
    end
  end

  assign we         = push;
  assign waddr      = wbin_q[AW-1:0];
  assign wgray      = wgray_q;
  assign drop_pulse = drop_q;
  assign ovf_err    = ovf_q;

  p_wgray_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));
  p_drop_rcol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> $past(is_r_col(in_col)));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_q) |-> ovf_q);
  p_wfill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_P);
endmodule

// File: rtl/ccomp_rd.sv
module ccomp_rd
  import ccomp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LO_MARK = 4,
  parameter int AW      = 4,
  parameter int PW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  col_t          rdata,
  input  logic [PW-1:0] wgray_s,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output col_t          out_col,
  output logic          ins_pulse,
  output logic          unf_err
);
  localparam logic [PW-1:0] LO_P   = PW'(LO_MARK);
  localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wbin, fill;
  logic          primed_q, primed_d, lastr_q, lastr_d;
  logic          ins_q, ins_d, unf_q, unf_d;
  col_t          out_q, out_d;

  always_comb begin
    wbin[PW-1] = wgray_s[PW-1];
    for (int i = PW-2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s[i];
  end

  always_comb begin
    fill     = wbin - rbin_q;
    primed_d = primed_q;
    lastr_d  = lastr_q;
    rbin_d   = rbin_q;
    out_d    = idle_col();
    ins_d    = 1'b0;
    unf_d    = unf_q;
    if (!primed_q) begin
      if (fill >= HALF_P) primed_d = 1'b1;
    end else if (lastr_q && (fill <= LO_P)) begin
      ins_d = 1'b1;
    end else if (fill == '0) begin
      unf_d = 1'b1;
    end else begin
      out_d   = xlate(rdata);
      lastr_d = is_r_col(rdata);
      rbin_d  = rbin_q + 1'b1;
    end
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      primed_q <= 1'b0;
      lastr_q  <= 1'b0;
      ins_q    <= 1'b0;
      unf_q    <= 1'b0;
      out_q    <= idle_col();
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= rgray_d;
      primed_q <= primed_d;
      lastr_q  <= lastr_d;
      ins_q    <= ins_d;
      unf_q    <= unf_d;
      out_q    <= out_d;
    end
  end

  assign raddr     = rbin_q[AW-1:0];
  assign rgray     = rgray_q;
  assign out_col   = out_q;
  assign ins_pulse = ins_q;
  assign unf_err   = unf_q;

  p_rgray_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgray_q ^ $past(rgray_q)));
  p_ins_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_q |-> (out_q == idle_col()));
  p_out_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !has_gap_char(out_q));
  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unf_q) |-> unf_q);
  p_rfill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_P);
endmodule

// File: rtl/lane_ccomp_fifo.sv
module lane_ccomp_fifo
  import ccomp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 4
) (
  input  logic                 wr_clk,
  input  logic                 wr_rst_n,
  input  logic [8*NLANE-1:0]   in_data,
  input  logic [NLANE-1:0]     in_ctrl,
  output logic                 col_drop,
  output logic                 ovf_err,
  input  logic                 rd_clk,
  input  logic                 rd_rst_n,
  output logic [8*NLANE-1:0]   out_data,
  output logic [NLANE-1:0]     out_ctrl,
  output logic                 col_ins,
  output logic                 unf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  col_t          in_col, rd_col, o_col;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  assign in_col.ctl = in_ctrl;
  assign in_col.dat = in_data;

  ccomp_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));

  ccomp_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));

  ccomp_wr #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_col(in_col), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .drop_pulse(col_drop),
    .ovf_err(ovf_err));

  ccomp_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(in_col),
    .raddr(raddr), .rdata(rd_col));

  ccomp_rd #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rdata(rd_col), .wgray_s(wgray_s),
    .raddr(raddr), .rgray(rgray), .out_col(o_col), .ins_pulse(col_ins),
    .unf_err(unf_err));

  assign out_data = o_col.dat;
  assign out_ctrl = o_col.ctl;
endmodule

// File: tb/lane_ccomp_fifo_tb.sv
`timescale 1ns/1ps
module lane_ccomp_fifo_tb;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic [31:0] in_data = 32'hBCBCBCBC;
  logic [3:0]  in_ctrl = 4'hF;
  logic [31:0] out_data;
  logic [3:0]  out_ctrl;
  logic        col_drop, ovf_err, col_ins, unf_err;
  real         wr_half = 1.9;

  always #(wr_half) wr_clk = ~wr_clk;
  always #2 rd_clk = ~rd_clk;

  lane_ccomp_fifo u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
    .col_drop(col_drop), .ovf_err(ovf_err), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .out_data(out_data), .out_ctrl(out_ctrl), .col_ins(col_ins), .unf_err(unf_err));

  int n_chk = 0, n_fail = 0;
  int drops = 0, inserts = 0, wr_edges = 0, cyc = 0;
  bit cmp_en = 0, mon_en = 0, seen_data = 0, prev_r = 0, done = 0;
  logic [35:0] expq[$];
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] ref_xlate(logic [3:0] c, logic [31:0] d);
    logic [31:0] o = d;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = d[8*i +: 8];
      if (c[i] && (b == 8'h1C || b == 8'h7C || b == 8'hBC)) o[8*i +: 8] = 8'h07;
    end
    return {c, o};
  endfunction

  function automatic bit all_idle(logic [35:0] x);
    return x == {4'hF, 32'h07070707};
  endfunction

  always @(posedge wr_clk) if (wr_rst_n) wr_edges++;

  task automatic send(logic [3:0] c, logic [31:0] d);
    logic [35:0] t;
    @(negedge wr_clk);
    if (col_drop) begin
      drops++;
      chk(prev_r, "R4", "drop of non-/R/ column", {63'd0, col_drop}, 64'd0);
    end
    in_ctrl = c;
    in_data = d;
    prev_r = (c == 4'hF) && (d == 32'h1C1C1C1C);
    t = ref_xlate(c, d);
    if (cmp_en && !all_idle(t)) expq.push_back(t);
  endtask

  function automatic logic [7:0] rnd8();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  task automatic send_pkt(int len, int gap);
    logic [31:0] d;
    int tl;
    send(4'b0001, {rnd8(), rnd8(), rnd8(), 8'hFB});
    for (int k = 0; k < len; k++) send(4'b0000, {rnd8(), rnd8(), rnd8(), rnd8()});
    tl = len % 4;
    d = 32'h0;
    for (int i = 0; i < 4; i++) begin
      if (i < tl) d[8*i +: 8] = rnd8();
      else if (i == tl) d[8*i +: 8] = 8'hFD;
      else d[8*i +: 8] = 8'hBC;
    end
    send(4'hF << tl, d);
    send(4'hF, 32'h7C7C7C7C);
    for (int k = 0; k < gap; k++) send(4'hF, 32'h1C1C1C1C);
    send(4'hF, 32'hBCBCBCBC);
    for (int k = 0; k < 3; k++) send(4'hF, 32'h1C1C1C1C);
  endtask

  always @(negedge rd_clk) begin
    if (rd_rst_n && mon_en) begin
      logic [35:0] o, e;
      o = {out_ctrl, out_data};
      for (int i = 0; i < 4; i++) begin
        logic [7:0] b = out_data[8*i +: 8];
        chk(!(out_ctrl[i] && (b == 8'h1C || b == 8'h7C || b == 8'hBC)), "R6",
            "raw gap code on output", {56'd0, b}, 64'h07);
      end
      if (col_ins) begin
        inserts++;
        chk(all_idle(o), "R5", "inserted column not Idle", {28'd0, o}, {28'd0, 4'hF, 32'h07070707});
      end
      if (!all_idle(o)) begin
        if (!seen_data) begin
          seen_data = 1;
          chk(wr_edges >= 8, "R2", "data before half full", 64'(wr_edges), 64'd8);
        end
        if (cmp_en) begin
          if (expq.size() == 0) chk(0, "R3", "unexpected column", {28'd0, o}, 64'd0);
          else begin
            e = expq.pop_front();
            chk(o == e, "R3 R6", "column mismatch", {28'd0, o}, {28'd0, e});
          end
        end
      end
    end
  end

  task automatic do_reset();
    mon_en = 0; cmp_en = 0;
    wr_rst_n = 0; rd_rst_n = 0;
    in_ctrl = 4'hF; in_data = 32'hBCBCBCBC; prev_r = 0;
    repeat (4) @(posedge rd_clk);
    expq.delete();
    seen_data = 0; wr_edges = 0;
    @(negedge rd_clk);
    chk({out_ctrl, out_data} == {4'hF, 32'h07070707}, "R1", "reset output",
        {28'd0, out_ctrl, out_data}, {28'd0, 4'hF, 32'h07070707});
    chk(!col_ins && !unf_err, "R1", "read flags in reset", {62'd0, col_ins, unf_err}, 64'd0);
    chk(!col_drop && !ovf_err, "R1", "write flags in reset", {62'd0, col_drop, ovf_err}, 64'd0);
    rd_rst_n = 1;
    @(negedge wr_clk);
    wr_rst_n = 1;
    mon_en = 1;
  endtask

  always @(posedge rd_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      chk(0, "WDOG", "watchdog expired", 64'(cyc), 64'd150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    cmp_en = 1;
    wr_half = 1.9;
    for (int p = 0; p < 60; p++) send_pkt(4 + p % 17, 2 + p % 5);
    chk(drops > 0, "R4", "no drop with fast writer", 64'(drops), 64'd1);
    wr_half = 2.1;
    for (int p = 0; p < 60; p++) send_pkt(4 + p % 17, 2 + p % 5);
    for (int k = 0; k < 60; k++) send(4'hF, 32'h1C1C1C1C);
    chk(inserts > 0, "R5", "no insert with slow writer", 64'(inserts), 64'd1);
    chk(expq.size() == 0, "R3", "columns not delivered", 64'(expq.size()), 64'd0);
    chk(!ovf_err, "R7", "false overflow", {63'd0, ovf_err}, 64'd0);
    chk(!unf_err, "R8", "false underflow", {63'd0, unf_err}, 64'd0);

    do_reset();
    wr_half = 1.9;
    for (int k = 0; k < 300; k++) send(4'h0, {rnd8(), rnd8(), rnd8(), rnd8()});
    chk(ovf_err, "R7", "overflow not flagged", {63'd0, ovf_err}, 64'd1);
    for (int k = 0; k < 20; k++) send(4'hF, 32'hBCBCBCBC);
    chk(ovf_err, "R7", "overflow not sticky", {63'd0, ovf_err}, 64'd1);

    do_reset();
    wr_half = 2.1;
    for (int k = 0; k < 400; k++) send(4'h0, {rnd8(), rnd8(), rnd8(), rnd8()});
    @(negedge rd_clk);
    chk(unf_err, "R8", "underflow not flagged", {63'd0, unf_err}, 64'd1);
    for (int k = 0; k < 20; k++) send(4'hF, 32'hBCBCBCBC);
    @(negedge rd_clk);
    chk(unf_err, "R8", "underflow not sticky", {63'd0, unf_err}, 64'd1);

    do_reset();
    @(negedge rd_clk);
    chk(!ovf_err && !unf_err, "R7 R8", "flags cleared by reset", {62'd0, ovf_err, unf_err}, 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule